// File: doc/BRIEF.md
# PWM Fault Protection Controller

This block guards a PWM output stage against an external fault input. The fault input is brought into the clock domain by a synchronizer. A rising edge of the synchronized level sets a sticky event flag. While a fault is present, the block forces the PWM channels chosen by a disable mask to their inactive level (0). It raises an interrupt request when the flag is set and software has enabled interrupts. Output disabling always happens, whatever the interrupt enable says.

Software uses a small byte-wide register interface with a combinational read path. The control register (address 0) holds the recovery mode in bit 0 (1 = automatic, 0 = manual) and the interrupt enable in bit 1. The status register (address 1) is read-only. It shows the synchronized fault level in bit 1 and the event flag in bit 0. The acknowledge register (address 2) clears the flag when written with bit 0 set, and it reads as 0.

Release of the outputs is handled by a three-state machine:
- `ST_RUN`: outputs follow the PWM inputs.
- `ST_TRIPPED`: the outputs are gated.
- `ST_ARMED`: the outputs are still gated, and release waits only for the PWM cycle boundary.

The transitions are:
- **trip**: RUN to TRIPPED, taken when the synchronized fault is high.
- **clear**: TRIPPED to ARMED. It needs the fault low and, in manual mode only, the flag cleared.
- **retrip**: ARMED to TRIPPED, taken when the fault returns, or when manual mode is in force with the flag set.
- **release**: ARMED to RUN, taken on a `cyc_end` pulse.

Top module: `pwm_fault_guard`

## Requirements
- R1: After reset, control reads 0 (manual mode, interrupt disabled), the flag is 0, `irq` is 0 and, with the fault input low, `pwm_out` equals `pwm_in`.
- R2: Control register bits 1:0 take the written value. Bits 7:2 read 0 whatever is written.
- R3: Status bit 1 shows the fault input level after two clock edges of synchronizer delay. Status bits 7:2 read 0. Writes to the status address change nothing.
- R4: The flag sets on the clock edge where a rising edge of the synchronized fault is seen. It then stays set after the fault returns low.
- R5: The flag clears only on a write to address 2 with data bit 0 = 1. A write there with bit 0 = 0 leaves it set. Address 2 reads 0.
- R6: If an acknowledge write and a rising edge fall on the same clock edge, the flag ends set.
- R7: `irq` is 1 exactly when the flag is 1 and control bit 1 is 1.
- R8: While the synchronized fault is high, `pwm_out = pwm_in & ~dis_mask`, with interrupts enabled or not.
- R9: In automatic mode, the outputs are released on the first `cyc_end` after the fault has gone low and the state has reached ARMED, even with the flag still set.
- R10: In manual mode, the outputs stay gated until the fault is low and the flag is cleared. Release then waits for a later `cyc_end`.
- R11: A `cyc_end` pulse while the fault is still high does not release the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 acknowledge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| fault_pin | input | 1 | External fault input, asynchronous |
| cyc_end | input | 1 | One-cycle pulse at each PWM cycle boundary |
| pwm_in | input | NUM_CH | Channel levels from the PWM generator |
| dis_mask | input | NUM_CH | Channels to force inactive on a fault |
| pwm_out | output | NUM_CH | Gated channel levels |
| irq | output | 1 | Interrupt request |

## Verification
A flag that is set when it should not be shows up at once in status bit 0, and in `irq` if the enable is set. A flag that fails to set shows up on the clock edge after the synchronized edge. A state machine stuck in TRIPPED or ARMED leaves `pwm_out` gated after a boundary pulse that should have released it. A premature RUN state passes the PWM inputs through while the mask should hold them, and this is visible one cycle after the wrong transition. The bench therefore samples `pwm_out` just before and just after each boundary pulse, and reads the status register at each synchronizer step.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_ACK  = 2'd2;

    localparam logic [DATA_W-1:0] CTRL_MASK = 8'h03;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_TRIPPED = 2'd1,
        ST_ARMED   = 2'd2
    } gate_state_t;
endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic rise
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[CHAIN_W-2:0], pin};
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~chain[STAGES];

    p_rise_single_r4: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/pfg_regs.sv
module pfg_regs
    import pfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              fault_lvl,
    input  logic              fault_rise,
    output logic              int_en,
    output logic              auto_mode,
    output logic              flag
);
    logic [DATA_W-1:0] ctrl_q;
    logic              ctrl_we;
    logic              ack;

    assign ctrl_we = bus_sel & bus_wr & (bus_addr == ADDR_CTRL);
    assign ack     = bus_sel & bus_wr & (bus_addr == ADDR_ACK) & bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= bus_wdata & CTRL_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst)             flag <= 1'b0;
        else if (fault_rise) flag <= 1'b1;
        else if (ack)        flag <= 1'b0;
    end

    assign int_en    = ctrl_q[1];
    assign auto_mode = ctrl_q[0];

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = ctrl_q;
            ADDR_STAT: bus_rdata = {{(DATA_W-2){1'b0}}, fault_lvl, flag};
            default:   bus_rdata = '0;
        endcase
    end

    p_flag_set_r4: assert property (@(posedge clk) disable iff (rst)
        fault_rise |=> flag);
    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (flag && !ack) |=> flag);
    p_ack_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (ack && !fault_rise) |=> !flag);
    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (ack && fault_rise) |=> flag);
    p_ctrl_upper_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_CTRL) |-> (bus_rdata[DATA_W-1:2] == '0));
endmodule

// File: rtl/pfg_fsm.sv
module pfg_fsm
    import pfg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fault_lvl,
    input  logic flag,
    input  logic auto_mode,
    input  logic cyc_end,
    output logic gate
);
    gate_state_t state_q, state_d;
    logic        running;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (fault_lvl) state_d = ST_TRIPPED;
            end
            ST_TRIPPED: begin
                if (!fault_lvl && (auto_mode || !flag)) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (fault_lvl)                   state_d = ST_TRIPPED;
                else if (!auto_mode && flag)     state_d = ST_TRIPPED;
                else if (cyc_end)                state_d = ST_RUN;
            end
            default: state_d = ST_TRIPPED;
        endcase
    end

    always_comb begin
        running = (state_q == ST_RUN);
        gate    = !running || fault_lvl;
    end

    p_fault_gates_r8: assert property (@(posedge clk) disable iff (rst)
        fault_lvl |-> gate);
    p_release_boundary_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> $past(cyc_end));
    p_release_fault_low_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> !$past(fault_lvl));
    p_manual_release_r10: assert property (@(posedge clk) disable iff (rst)
        ($rose(running) && !$past(auto_mode)) |-> !$past(flag));
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
    import pfg_pkg::*;
#(
    parameter int NUM_CH      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              fault_pin,
    input  logic              cyc_end,
    input  logic [NUM_CH-1:0] pwm_in,
    input  logic [NUM_CH-1:0] dis_mask,
    output logic [NUM_CH-1:0] pwm_out,
    output logic              irq
);
    logic fault_lvl, fault_rise;
    logic int_en, auto_mode, flag;
    logic gate;

    pfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin   (fault_pin),
        .level (fault_lvl),
        .rise  (fault_rise)
    );

    pfg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .fault_lvl  (fault_lvl),
        .fault_rise (fault_rise),
        .int_en     (int_en),
        .auto_mode  (auto_mode),
        .flag       (flag)
    );

    pfg_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .fault_lvl (fault_lvl),
        .flag      (flag),
        .auto_mode (auto_mode),
        .cyc_end   (cyc_end),
        .gate      (gate)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        assign pwm_out[ch] = pwm_in[ch] & ~(dis_mask[ch] & gate);
    end

    assign irq = flag & int_en;

    p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
        !int_en |-> !irq);
    p_masked_low_r8: assert property (@(posedge clk) disable iff (rst)
        fault_lvl |-> ((pwm_out & dis_mask) == '0));
endmodule

// File: tb/sim_pwm_fault_guard.sv
module sim_pwm_fault_guard;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       fault_pin = 1'b0, cyc_end = 1'b0;
    logic [N-1:0] pwm_in = 4'b1011, dis_mask = 4'b0110;
    logic [N-1:0] pwm_out;
    logic       irq;

    int total = 0, bad = 0;
    bit done = 0;
    logic [7:0] rv;

    always #10 clk = ~clk;

    pwm_fault_guard #(.NUM_CH(N), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fault_pin(fault_pin), .cyc_end(cyc_end), .pwm_in(pwm_in),
        .dis_mask(dis_mask), .pwm_out(pwm_out), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic boundary();
        cyc_end = 1'b1;
        tick();
        cyc_end = 1'b0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, rv); chk("R1 ctrl", rv, 8'h00);
        rd(2'd1, rv); chk("R1 status", rv, 8'h00);
        chk("R1 irq", irq, 1'b0);
        chk("R1 pwm pass", pwm_out, pwm_in);

        // R2 control sweep over all write values
        for (int v = 0; v < 256; v++) begin
            wr(2'd0, v[7:0]);
            rd(2'd0, rv);
            chk("R2 ctrl readback", rv, v & 8'h03);
        end
        wr(2'd0, 8'h00);

        // R3 status write ignored, R5 ack reads 0
        wr(2'd1, 8'hFF);
        rd(2'd1, rv); chk("R3 status write ignored", rv, 8'h00);
        rd(2'd2, rv); chk("R5 ack reads zero", rv, 8'h00);

        // R3 synchronizer delay
        fault_pin = 1'b1;
        tick();
        rd(2'd1, rv); chk("R3 level after one edge", rv, 8'h00);
        tick();
        rd(2'd1, rv); chk("R3 level after two edges", rv, 8'h02);
        // R8 gating with interrupts disabled, full sweep
        for (int p = 0; p < 16; p++) begin
            for (int m = 0; m < 16; m++) begin
                pwm_in = p[N-1:0]; dis_mask = m[N-1:0];
                #1 chk("R8 gate sweep", pwm_out, p[N-1:0] & ~m[N-1:0]);
            end
        end
        pwm_in = 4'b1011; dis_mask = 4'b0110;
        tick();
        rd(2'd1, rv); chk("R4 flag set", rv, 8'h03);
        chk("R7 no irq when disabled", irq, 1'b0);
        wr(2'd1, 8'h00);
        rd(2'd1, rv); chk("R3 status write keeps flag", rv, 8'h03);

        // R7 enable interrupt, manual mode
        wr(2'd0, 8'h02);
        chk("R7 irq asserted", irq, 1'b1);

        // R4 sticky, R10 manual hold
        fault_pin = 1'b0;
        repeat (3) tick();
        rd(2'd1, rv); chk("R4 flag sticky", rv, 8'h01);
        boundary();
        chk("R10 held with flag set", pwm_out, 4'b1001);
        wr(2'd2, 8'h00);
        rd(2'd1, rv); chk("R5 ack bit0 zero no effect", rv, 8'h01);
        wr(2'd2, 8'h01);
        rd(2'd1, rv); chk("R5 ack clears", rv, 8'h00);
        chk("R7 irq drops", irq, 1'b0);
        tick();
        chk("R10 waits for boundary", pwm_out, 4'b1001);
        boundary();
        chk("R10 released", pwm_out, 4'b1011);

        // R9 / R11 automatic mode
        wr(2'd0, 8'h01);
        fault_pin = 1'b1;
        repeat (3) tick();
        chk("R8 gated auto", pwm_out, 4'b1001);
        boundary();
        chk("R11 boundary during fault", pwm_out, 4'b1001);
        fault_pin = 1'b0;
        repeat (3) tick();
        chk("R9 waits boundary", pwm_out, 4'b1001);
        boundary();
        chk("R9 released", pwm_out, 4'b1011);
        rd(2'd1, rv); chk("R9 flag still set", rv, 8'h01);

        // R7 irq in auto mode with enable
        wr(2'd0, 8'h03);
        chk("R7 irq auto", irq, 1'b1);
        wr(2'd2, 8'h01);
        chk("R7 irq cleared", irq, 1'b0);

        // R6 ack on the same edge as a rising edge
        fault_pin = 1'b1;
        tick();
        tick();
        wr(2'd2, 8'h01);
        rd(2'd1, rv); chk("R6 set wins", rv, 8'h03);
        chk("R6 irq", irq, 1'b1);
        wr(2'd2, 8'h01);
        rd(2'd1, rv); chk("R5 later ack clears", rv, 8'h02);

        done = 1;
        summary();
        $finish;
    end
endmodule